// File: doc/BRIEF.md
# Right-to-Left Modular Exponentiation Sequencer

This block computes P^D mod N by directing an external Montgomery multiplier. It does no arithmetic itself. A caller presents the message P, the exponent D with its bit length, the odd modulus N, the precomputed word constant N' = -N^-1 mod 2^DIGIT_W, and R^2 mod N, where R = 2^(DIGIT_W*NUM_DIGITS). It then pulses a start input. The sequencer latches all of these and issues a fixed series of Montgomery multiply requests. For each request it drives an operation code, two operand values, the modulus and N', together with a one-cycle start pulse. It then waits for the multiplier's done pulse and writes the returned product into one of its digit register banks.

The exponent is consumed from its least significant bit upward. Two values are kept in the Montgomery domain: a running square and an accumulator. Two conversion requests seed them at the start. For each exponent bit, the accumulator is multiplied by the current square if the bit is one, and the square is then squared. A final request multiplies the accumulator by 1 to leave the Montgomery domain. When that product returns, the block pulses done and holds the result until the next accepted start.

Top module: `mexp_seq`

## Requirements
- R1: When idle, a start pulse latches message, exponent, length, modulus, N' and R^2 mod N, and raises busy from the next cycle. Every request drives the latched modulus and N'. A start pulse while busy is ignored and alters neither the requests nor the result.
- R2: The first request has op code 0 with operands (P, R^2 mod N) and seeds the square chain. The second has op code 1 with operands (1, R^2 mod N) and seeds the accumulator.
- R3: Exactly the low L exponent bits are used, L being the length input clamped to EXP_W. They are used in order from bit 0 upward, and exponent bits at or above L have no effect.
- R4: For an exponent bit of 1, a multiply request (op code 2, operands accumulator and square) is issued. It is followed directly by the square request (op code 3, operands square and square), so the multiply uses the square from before that iteration's squaring.
- R5: For an exponent bit of 0, only the square request is issued and the accumulator keeps its value.
- R6: The last request has op code 4 with operands (accumulator, 1), and its product becomes the result.
- R7: One exponentiation issues exactly 3 + L + (number of ones among the low L bits) requests; D = 65537 with L = 17 gives 22.
- R8: done pulses for exactly one cycle with result equal to P^D mod N. The result then stays stable while the block is idle.
- R9: A length of 0 gives a result of 1 after 3 requests.
- R10: At most one request is outstanding. A new request start is never driven before the previous done. Op code and operands stay stable while a request is pending.
- R11: After reset, busy, done and the request start are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an exponentiation when idle |
| msg_i | input | DIGIT_W*NUM_DIGITS | Message P |
| exp_i | input | EXP_W | Exponent D |
| exp_len_i | input | LEN_W | Number of exponent bits to use |
| mod_i | input | DIGIT_W*NUM_DIGITS | Odd modulus N |
| nprime_i | input | DIGIT_W | -N^-1 mod 2^DIGIT_W |
| r2_i | input | DIGIT_W*NUM_DIGITS | R^2 mod N |
| busy_o | output | 1 | Exponentiation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | DIGIT_W*NUM_DIGITS | P^D mod N |
| mm_start_o | output | 1 | Multiply request pulse |
| mm_op_o | output | 3 | Request kind code |
| mm_a_o | output | DIGIT_W*NUM_DIGITS | First operand |
| mm_b_o | output | DIGIT_W*NUM_DIGITS | Second operand |
| mm_mod_o | output | DIGIT_W*NUM_DIGITS | Modulus for the multiplier |
| mm_nprime_o | output | DIGIT_W | N' for the multiplier |
| mm_done_i | input | 1 | Multiplier done pulse |
| mm_res_i | input | DIGIT_W*NUM_DIGITS | Multiplier product |

## Verification
The bench builds the sequencer with 8-bit digits, three digits and a 20-bit exponent. This makes operands 24 bits wide, so a bit-serial Montgomery model and a plain square-and-multiply reference both fit in 64-bit bench arithmetic. It also makes a 17-bit exponent such as 65537 cheap to run. The small exponent width lets the bench drive length values that leave set bits above the used range, and runs with length zero, an all-zero exponent and a dense exponent complete in a few hundred cycles. The responder varies its latency per request, so the operand-hold and single-outstanding rules are exercised with gaps of one to three cycles.

// File: rtl/mexp_pkg.sv
package mexp_pkg;
  typedef enum logic [2:0] {
    OP_TO_SQ = 3'd0,
    OP_TO_CC = 3'd1,
    OP_MUL   = 3'd2,
    OP_SQR   = 3'd3,
    OP_FROM  = 3'd4
  } mexp_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_DECIDE
  } mexp_st_e;
endpackage

// File: rtl/mexp_digit_bank.sv
module mexp_digit_bank #(
  parameter int DIGIT_W    = 32,
  parameter int NUM_DIGITS = 33
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          load_i,
  input  logic [DIGIT_W*NUM_DIGITS-1:0] data_i,
  output logic [DIGIT_W*NUM_DIGITS-1:0] data_o
);
  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_dig
    logic [DIGIT_W-1:0] dig_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     dig_q <= '0;
      else if (load_i) dig_q <= data_i[g*DIGIT_W +: DIGIT_W];
    end
    assign data_o[g*DIGIT_W +: DIGIT_W] = dig_q;
  end
endmodule

// File: rtl/mexp_bit_scan.sv
module mexp_bit_scan #(
  parameter int EXP_W = 1024,
  parameter int LEN_W = $clog2(EXP_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             shift_i,
  output logic             bit_o,
  output logic             empty_o
);
  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(EXP_W);

  logic [EXP_W-1:0] exp_q;
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] len_clamp;

  assign len_clamp = (len_i > MAX_LEN) ? MAX_LEN : len_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      exp_q <= exp_i;
      cnt_q <= len_clamp;
    end else if (shift_i && cnt_q != '0) begin
      exp_q <= exp_q >> 1;
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign bit_o   = exp_q[0];
  assign empty_o = (cnt_q == '0);
endmodule

// File: rtl/mexp_ctrl.sv
module mexp_ctrl
  import mexp_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  input  logic     bit_i,
  input  logic     empty_i,
  input  logic     mm_done_i,
  output mexp_op_e op_o,
  output logic     mm_start_o,
  output logic     accept_o,
  output logic     load_sq_o,
  output logic     load_cc_o,
  output logic     load_res_o,
  output logic     shift_o,
  output logic     busy_o,
  output logic     done_o
);
  mexp_st_e st_q;
  mexp_op_e op_q;
  logic     start_q, done_q, fin;

  assign fin        = (st_q == ST_WAIT) && mm_done_i;
  assign accept_o   = (st_q == ST_IDLE) && start_i;
  assign load_sq_o  = fin && (op_q == OP_TO_SQ || op_q == OP_SQR);
  assign load_cc_o  = fin && (op_q == OP_TO_CC || op_q == OP_MUL);
  assign load_res_o = fin && (op_q == OP_FROM);
  assign shift_o    = fin && (op_q == OP_SQR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      op_q    <= OP_TO_SQ;
      start_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      start_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          op_q <= OP_TO_SQ;
          st_q <= ST_ISSUE;
        end
        ST_ISSUE: begin
          start_q <= 1'b1;
          st_q    <= ST_WAIT;
        end
        ST_WAIT: if (mm_done_i) begin
          unique case (op_q)
            OP_TO_SQ: begin op_q <= OP_TO_CC; st_q <= ST_ISSUE; end
            OP_MUL:   begin op_q <= OP_SQR;   st_q <= ST_ISSUE; end
            OP_FROM:  begin done_q <= 1'b1;   st_q <= ST_IDLE;  end
            default:  st_q <= ST_DECIDE;   // after seeding or squaring
          endcase
        end
        ST_DECIDE: begin
          // scanner has shifted; bit_i is the next exponent bit
          if (empty_i)    op_q <= OP_FROM;
          else if (bit_i) op_q <= OP_MUL;
          else            op_q <= OP_SQR;
          st_q <= ST_ISSUE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign op_o       = op_q;
  assign mm_start_o = start_q;
  assign busy_o     = (st_q != ST_IDLE);
  assign done_o     = done_q;
endmodule

// File: rtl/mexp_seq.sv
module mexp_seq
  import mexp_pkg::*;
#(
  parameter int DIGIT_W    = 32,
  parameter int NUM_DIGITS = 33,
  parameter int EXP_W      = 1024,
  parameter int LEN_W      = $clog2(EXP_W + 1)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic [DIGIT_W*NUM_DIGITS-1:0] msg_i,
  input  logic [EXP_W-1:0]              exp_i,
  input  logic [LEN_W-1:0]              exp_len_i,
  input  logic [DIGIT_W*NUM_DIGITS-1:0] mod_i,
  input  logic [DIGIT_W-1:0]            nprime_i,
  input  logic [DIGIT_W*NUM_DIGITS-1:0] r2_i,
  output logic                          busy_o,
  output logic                          done_o,
  output logic [DIGIT_W*NUM_DIGITS-1:0] result_o,
  output logic                          mm_start_o,
  output logic [2:0]                    mm_op_o,
  output logic [DIGIT_W*NUM_DIGITS-1:0] mm_a_o,
  output logic [DIGIT_W*NUM_DIGITS-1:0] mm_b_o,
  output logic [DIGIT_W*NUM_DIGITS-1:0] mm_mod_o,
  output logic [DIGIT_W-1:0]            mm_nprime_o,
  input  logic                          mm_done_i,
  input  logic [DIGIT_W*NUM_DIGITS-1:0] mm_res_i
);
  localparam int OPW = DIGIT_W * NUM_DIGITS;
  localparam logic [OPW-1:0] ONE = OPW'(1);

  mexp_op_e       op;
  logic           accept, load_sq, load_cc, load_res, shift, cur_bit, empty;
  logic [OPW-1:0] msg_q, r2_q, sq_q, cc_q;

  mexp_ctrl u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .bit_i(cur_bit), .empty_i(empty), .mm_done_i,
    .op_o(op), .mm_start_o, .accept_o(accept),
    .load_sq_o(load_sq), .load_cc_o(load_cc), .load_res_o(load_res),
    .shift_o(shift), .busy_o, .done_o
  );

  mexp_bit_scan #(.EXP_W(EXP_W), .LEN_W(LEN_W)) u_scan (
    .clk_i, .rst_ni, .load_i(accept), .exp_i, .len_i(exp_len_i),
    .shift_i(shift), .bit_o(cur_bit), .empty_o(empty)
  );

  // latched inputs
  mexp_digit_bank #(.DIGIT_W(DIGIT_W), .NUM_DIGITS(NUM_DIGITS)) u_msg (
    .clk_i, .rst_ni, .load_i(accept), .data_i(msg_i), .data_o(msg_q));
  mexp_digit_bank #(.DIGIT_W(DIGIT_W), .NUM_DIGITS(NUM_DIGITS)) u_r2 (
    .clk_i, .rst_ni, .load_i(accept), .data_i(r2_i), .data_o(r2_q));
  mexp_digit_bank #(.DIGIT_W(DIGIT_W), .NUM_DIGITS(NUM_DIGITS)) u_mod (
    .clk_i, .rst_ni, .load_i(accept), .data_i(mod_i), .data_o(mm_mod_o));
  mexp_digit_bank #(.DIGIT_W(DIGIT_W), .NUM_DIGITS(1)) u_np (
    .clk_i, .rst_ni, .load_i(accept), .data_i(nprime_i), .data_o(mm_nprime_o));

  // Montgomery-domain chains and result
  mexp_digit_bank #(.DIGIT_W(DIGIT_W), .NUM_DIGITS(NUM_DIGITS)) u_sq (
    .clk_i, .rst_ni, .load_i(load_sq), .data_i(mm_res_i), .data_o(sq_q));
  mexp_digit_bank #(.DIGIT_W(DIGIT_W), .NUM_DIGITS(NUM_DIGITS)) u_cc (
    .clk_i, .rst_ni, .load_i(load_cc), .data_i(mm_res_i), .data_o(cc_q));
  mexp_digit_bank #(.DIGIT_W(DIGIT_W), .NUM_DIGITS(NUM_DIGITS)) u_res (
    .clk_i, .rst_ni, .load_i(load_res), .data_i(mm_res_i), .data_o(result_o));

  always_comb begin
    unique case (op)
      OP_TO_SQ: begin mm_a_o = msg_q; mm_b_o = r2_q; end
      OP_TO_CC: begin mm_a_o = ONE;   mm_b_o = r2_q; end
      OP_MUL:   begin mm_a_o = cc_q;  mm_b_o = sq_q; end
      OP_SQR:   begin mm_a_o = sq_q;  mm_b_o = sq_q; end
      default:  begin mm_a_o = cc_q;  mm_b_o = ONE;  end
    endcase
  end

  assign mm_op_o = op;
endmodule

// File: rtl/mexp_seq_chk.sv
module mexp_seq_chk #(
  parameter int OPW = 32
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic           busy_o,
  input logic           done_o,
  input logic [OPW-1:0] result_o,
  input logic           mm_start_o,
  input logic [2:0]     mm_op_o,
  input logic [OPW-1:0] mm_a_o,
  input logic [OPW-1:0] mm_b_o,
  input logic           mm_done_i
);
  logic       pend_q, first_q;
  logic [2:0] last_op_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q    <= 1'b0;
      first_q   <= 1'b0;
      last_op_q <= 3'd0;
    end else begin
      if (mm_start_o)     pend_q <= 1'b1;
      else if (mm_done_i) pend_q <= 1'b0;
      if (!busy_o && start_i) first_q <= 1'b1;
      else if (mm_start_o)    first_q <= 1'b0;
      if (mm_start_o) last_op_q <= mm_op_o;
    end
  end

  assert_single_pending_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mm_start_o |-> !pend_q);
  assert_request_while_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mm_start_o |-> busy_o);
  assert_operands_held_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !mm_done_i) |=> ($stable(mm_a_o) && $stable(mm_b_o) && $stable(mm_op_o)));
  assert_square_after_mul_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mm_start_o && last_op_q == 3'd2) |-> mm_op_o == 3'd3);
  assert_first_is_seed_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mm_start_o && first_q) |-> mm_op_o == 3'd0);
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_result_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(result_o));
  assert_idle_no_request_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mm_start_o);
endmodule

bind mexp_seq mexp_seq_chk #(.OPW(OPW)) u_chk (
  .clk_i, .rst_ni, .start_i, .busy_o, .done_o, .result_o,
  .mm_start_o, .mm_op_o, .mm_a_o, .mm_b_o, .mm_done_i
);

// File: tb/sim_mexp_seq.sv
module sim_mexp_seq;
  localparam int DW = 8, ND = 3, EW = 20, LW = 5, OPW = DW * ND;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [OPW-1:0] msg = '0, modv = '0, r2 = '0, mm_res = '0;
  logic [EW-1:0]  expv = '0;
  logic [LW-1:0]  len = '0;
  logic [DW-1:0]  np = '0;
  logic mm_done = 1'b0;
  logic busy, done, mm_start;
  logic [OPW-1:0] result, mm_a, mm_b, mm_mod;
  logic [2:0] mm_op;
  logic [DW-1:0] mm_np;

  always #2 clk = ~clk;  // 250 MHz

  mexp_seq #(.DIGIT_W(DW), .NUM_DIGITS(ND), .EXP_W(EW), .LEN_W(LW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .msg_i(msg), .exp_i(expv),
    .exp_len_i(len), .mod_i(modv), .nprime_i(np), .r2_i(r2), .busy_o(busy),
    .done_o(done), .result_o(result), .mm_start_o(mm_start), .mm_op_o(mm_op),
    .mm_a_o(mm_a), .mm_b_o(mm_b), .mm_mod_o(mm_mod), .mm_nprime_o(mm_np),
    .mm_done_i(mm_done), .mm_res_i(mm_res));

  int checks = 0, fails = 0, req_cnt = 0, bad_pass = 0;
  logic [2:0]     op_log [64];
  logic [OPW-1:0] a_log [64], b_log [64];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic longint mont(longint a, longint b, longint n);
    longint t = 0;
    for (int i = 0; i < OPW; i++) begin
      if (a[i]) t += b;
      if (t[0]) t += n;
      t = t >> 1;
    end
    if (t >= n) t -= n;
    return t;
  endfunction

  function automatic longint powmod(longint p, longint d, int l, longint n);
    longint r = 1 % n, s = p % n;
    for (int i = 0; i < l; i++) begin
      if (d[i]) r = (r * s) % n;
      s = (s * s) % n;
    end
    return r;
  endfunction

  // multiplier responder with varying latency
  initial begin
    forever begin
      @(negedge clk);
      if (mm_start) begin
        if (req_cnt < 64) begin
          op_log[req_cnt] = mm_op; a_log[req_cnt] = mm_a; b_log[req_cnt] = mm_b;
        end
        if (mm_mod != modv || mm_np != np) bad_pass++;
        req_cnt++;
        repeat (1 + req_cnt % 3) @(negedge clk);
        mm_res  = OPW'(mont(longint'(a_log[(req_cnt-1)%64]), longint'(b_log[(req_cnt-1)%64]),
                            longint'(mm_mod)));
        mm_done = 1'b1;
        @(negedge clk);
        mm_done = 1'b0;
      end
    end
  end

  task automatic launch(input longint p, input longint d, input int l, input longint n);
    longint r = 1, x = 1;
    for (int i = 0; i < 2 * OPW; i++) r = (r * 2) % n;
    for (int i = 0; i < 4; i++) x = (x * (2 - n * x)) & 8'hFF;
    @(negedge clk);
    msg = OPW'(p); expv = EW'(d); len = LW'(l); modv = OPW'(n); r2 = OPW'(r);
    np = DW'(-x); req_cnt = 0; bad_pass = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R1", "busy after start", busy, 1);
  endtask

  task automatic wait_done(output bit ok);
    int n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    ok = done;
  endtask

  task automatic check_run(input longint p, input longint d, input int l, input longint n,
                           input longint r2v);
    bit ok;
    int idx = 0;
    int eff = (l > EW) ? EW : l;
    int ones = 0;
    logic [2:0] expect_ops [64];
    longint exp_res = powmod(p, d, eff, n);
    wait_done(ok);
    chk(ok, "R8", "done seen", ok, 1);
    chk(result == OPW'(exp_res), "R8", "result", result, exp_res);
    expect_ops[idx++] = 3'd0; expect_ops[idx++] = 3'd1;
    for (int i = 0; i < eff; i++) begin
      if (d[i]) begin expect_ops[idx++] = 3'd2; ones++; end
      expect_ops[idx++] = 3'd3;
    end
    expect_ops[idx++] = 3'd4;
    chk(req_cnt == 3 + eff + ones, "R7", "request count", req_cnt, 3 + eff + ones);
    begin
      bit seq_ok = (req_cnt == idx);
      for (int i = 0; i < idx && i < req_cnt; i++) if (op_log[i] != expect_ops[i]) seq_ok = 0;
      chk(seq_ok, "R3", "op order from bit 0 upward (R4 R5)", req_cnt, idx);
    end
    chk(a_log[0] == OPW'(p) && b_log[0] == OPW'(r2v), "R2", "seed square operands",
        a_log[0], p);
    chk(a_log[1] == 1 && b_log[1] == OPW'(r2v), "R2", "seed accumulator operands",
        a_log[1], 1);
    chk(b_log[req_cnt-1] == 1, "R6", "final operand b", b_log[req_cnt-1], 1);
    chk(bad_pass == 0, "R1", "modulus and N' passed", bad_pass, 0);
    @(negedge clk);
    chk(!done, "R8", "done single cycle", done, 0);
    repeat (3) @(negedge clk);
    chk(result == OPW'(exp_res) && !busy, "R8", "result held idle", result, exp_res);
  endtask

  function automatic longint r2_of(longint n);
    longint r = 1;
    for (int i = 0; i < 2 * OPW; i++) r = (r * 2) % n;
    return r;
  endfunction

  localparam longint NMOD = 64'hC3A5B7;

  task automatic t_reset;
    chk(!busy && !done && !mm_start, "R11", "idle after reset",
        {busy, done, mm_start}, 0);
  endtask

  task automatic t_basic;  // D = 13
    launch(64'h123456, 13, 4, NMOD);
    check_run(64'h123456, 13, 4, NMOD, r2_of(NMOD));
  endtask

  task automatic t_f4;  // D = 65537
    launch(64'h0ABCDE, 65537, 17, NMOD);
    check_run(64'h0ABCDE, 65537, 17, NMOD, r2_of(NMOD));
    chk(req_cnt == 22, "R7", "65537 gives 22 requests", req_cnt, 22);
  endtask

  task automatic t_zero_len;
    launch(64'h4321, 20'hFFFFF, 0, NMOD);
    check_run(64'h4321, 0, 0, NMOD, r2_of(NMOD));
    chk(result == 1, "R9", "zero length result", result, 1);
    chk(req_cnt == 3, "R9", "zero length requests", req_cnt, 3);
  endtask

  task automatic t_high_bits;  // only low 3 bits (101) count
    launch(64'h777777, 20'hFFFF5, 3, 64'h9D0F31);
    check_run(64'h777777, 5, 3, 64'h9D0F31, r2_of(64'h9D0F31));
  endtask

  task automatic t_zero_bits;  // no multiplies
    bit no_mul = 1;
    launch(64'h55AA55, 0, 5, NMOD);
    check_run(64'h55AA55, 0, 5, NMOD, r2_of(NMOD));
    for (int i = 0; i < req_cnt && i < 64; i++) if (op_log[i] == 3'd2) no_mul = 0;
    chk(no_mul, "R5", "no multiply for zero bits", no_mul, 1);
    chk(result == 1, "R5", "accumulator unchanged", result, 1);
  endtask

  task automatic t_long;  // clamp: length above EXP_W
    launch(64'h2468AC, 20'hB5A3F, 31, NMOD);
    check_run(64'h2468AC, 20'hB5A3F, 31, NMOD, r2_of(NMOD));
  endtask

  task automatic t_busy_start;
    bit ok;
    int cnt;
    longint r2v = r2_of(NMOD);
    launch(64'h13579B, 11, 4, NMOD);
    repeat (5) @(negedge clk);
    msg = 24'h111111; modv = 24'h9D0F31; start = 1'b1;
    @(negedge clk);
    start = 1'b0; msg = 24'h13579B; modv = OPW'(NMOD);
    wait_done(ok);
    chk(result == OPW'(powmod(64'h13579B, 11, 4, NMOD)), "R1", "start while busy ignored",
        result, powmod(64'h13579B, 11, 4, NMOD));
    chk(bad_pass == 0 && a_log[0] == 24'h13579B && b_log[0] == OPW'(r2v), "R1",
        "latched inputs kept", a_log[0], 64'h13579B);
    cnt = req_cnt;
    repeat (40) @(negedge clk);
    chk(req_cnt == cnt && !busy, "R1", "no second run", req_cnt, cnt);
  endtask

  bit finished = 0;

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_basic();
    t_f4();
    t_zero_len();
    t_high_bits();
    t_zero_bits();
    t_long();
    t_busy_start();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule